// File: doc/BRIEF.md
# Table-Driven Supply Sequencer

This block steps through a user-programmed list of states to decide which of eight supply-enable outputs are on. It is used to bring rails up in order, take them down in order, and react to supervisory faults. Each state holds its own enable pattern and three exits. One exit advances when an input condition matches. One is taken when a fault condition matches. The last is taken when a timeout expires. Chaining timeouts gives delays, and a timeout used as a deadline gives a watchdog.

The inputs are eight fault or logic flags and one software control bit. The engine looks at them only on cycles where a slow time-base tick is high. A 100 kHz tick therefore bounds every state change to one 10 µs period. The state table lives in internal registers and is loaded through a simple write port. A sticky interrupt reports fault and timeout exits until it is cleared.

Top module: `seq_engine`

## Requirements
- R1: During and after reset the state is 0, `enables` is all zero and `irq` is low. Every table field resets to zero.
- R2: `enables` always equals the output-pattern field of the current state's table entry.
- R3: The state and its tick counter change only at a clock edge where `tick` is high. The new state is visible on the cycle after that edge.
- R4: A condition is built from a 9-bit input word: bit 8 is `sw_ctl` and bits 7:0 are `flags`. The condition is met when its mask is nonzero and the masked input equals the masked match value. A zero mask never matches.
- R5: If several exits are met on one tick, the fault exit wins over the advance exit, and the advance exit wins over the timeout exit.
- R6: A nonzero timeout value N is met on the Nth tick after the state was entered. A value of 0 disables the timeout. Every exit taken, including one back to the same state, restarts the count.
- R7: `irq` goes high after a tick that takes a fault exit or a timeout exit. It stays high until `irq_clr` is seen on a clock edge. If a new setting event and `irq_clr` fall on the same edge, `irq` stays high.
- R8: A write with `cfg_we` high stores the low bits of `cfg_wdata` into entry `cfg_addr`. The field is chosen by `cfg_field`: 0 output pattern, 1 advance mask, 2 advance match, 3 advance target, 4 fault mask, 5 fault match, 6 fault target, 7 timeout count, 8 timeout target. Writes with an address of 63 or above are dropped.
- R9: An exit whose target is 63 or above leaves the state unchanged, but it still restarts the tick counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flags | input | 8 | Fault and logic input flags |
| sw_ctl | input | 1 | Software control bit, condition bit 8 |
| tick | input | 1 | One-cycle pulse from the time base |
| cfg_we | input | 1 | Table write strobe |
| cfg_addr | input | 6 | Table entry (state) to write |
| cfg_field | input | 4 | Field code within the entry |
| cfg_wdata | input | 16 | Write data, low bits used |
| irq_clr | input | 1 | Clears the sticky interrupt |
| enables | output | 8 | Supply enable outputs |
| irq | output | 1 | Sticky interrupt |
| state | output | 6 | Current state index |

## Verification
A state change, the matching `enables` pattern and an `irq` set or clear all appear on the cycle after the edge where `tick` or `irq_clr` was high. A table write shows on `enables` one cycle after its edge. The bench drives inputs and samples outputs 1 ns after each rising edge, so every check sees exactly one edge's worth of change. A bench model steps the same edge and is compared against the design at that point. Directed cases pin down the exact state and interrupt expected for priority, timeout counting and invalid targets.

// File: rtl/seq_engine.sv
module seq_engine #(
  parameter int NIN = 8,
  parameter int NOUT = 8,
  parameter int SW = 6,
  parameter int NST = 63,
  parameter int TW = 16,
  parameter int DW = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NIN-1:0]  flags,
  input  logic            sw_ctl,
  input  logic            tick,
  input  logic            cfg_we,
  input  logic [SW-1:0]   cfg_addr,
  input  logic [3:0]      cfg_field,
  input  logic [DW-1:0]   cfg_wdata,
  input  logic            irq_clr,
  output logic [NOUT-1:0] enables,
  output logic            irq,
  output logic [SW-1:0]   state
);
  localparam int CW = NIN + 1;
  localparam logic [SW:0] NST_V = NST[SW:0];

  logic [NOUT-1:0] t_out [NST];
  logic [CW-1:0]   t_am  [NST];
  logic [CW-1:0]   t_av  [NST];
  logic [CW-1:0]   t_fm  [NST];
  logic [CW-1:0]   t_fv  [NST];
  logic [SW-1:0]   t_at  [NST];
  logic [SW-1:0]   t_ft  [NST];
  logic [SW-1:0]   t_tt  [NST];
  logic [TW-1:0]   t_tc  [NST];

  logic [TW-1:0] tcnt;
  logic [CW-1:0] cond;
  logic adv_hit, flt_hit, tmo_hit, fire, ev_irq;
  logic [SW-1:0] nxt;

  assign cond    = {sw_ctl, flags};
  assign adv_hit = (|t_am[state]) && (((cond ^ t_av[state]) & t_am[state]) == '0);
  assign flt_hit = (|t_fm[state]) && (((cond ^ t_fv[state]) & t_fm[state]) == '0);
  assign tmo_hit = (t_tc[state] != '0) && (({1'b0, tcnt} + 1'b1) >= {1'b0, t_tc[state]});
  assign nxt     = flt_hit ? t_ft[state] : adv_hit ? t_at[state] : t_tt[state];
  assign fire    = tick && (flt_hit || adv_hit || tmo_hit);
  assign ev_irq  = tick && (flt_hit || (tmo_hit && !adv_hit));
  assign enables = t_out[state];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= '0;
      tcnt  <= '0;
      irq   <= 1'b0;
      for (int i = 0; i < NST; i++) begin
        t_out[i] <= '0; t_am[i] <= '0; t_av[i] <= '0;
        t_fm[i]  <= '0; t_fv[i] <= '0; t_at[i] <= '0;
        t_ft[i]  <= '0; t_tt[i] <= '0; t_tc[i] <= '0;
      end
    end else begin
      if (cfg_we && ({1'b0, cfg_addr} < NST_V)) begin
        case (cfg_field)
          4'd0: t_out[cfg_addr] <= cfg_wdata[NOUT-1:0];
          4'd1: t_am[cfg_addr]  <= cfg_wdata[CW-1:0];
          4'd2: t_av[cfg_addr]  <= cfg_wdata[CW-1:0];
          4'd3: t_at[cfg_addr]  <= cfg_wdata[SW-1:0];
          4'd4: t_fm[cfg_addr]  <= cfg_wdata[CW-1:0];
          4'd5: t_fv[cfg_addr]  <= cfg_wdata[CW-1:0];
          4'd6: t_ft[cfg_addr]  <= cfg_wdata[SW-1:0];
          4'd7: t_tc[cfg_addr]  <= cfg_wdata[TW-1:0];
          4'd8: t_tt[cfg_addr]  <= cfg_wdata[SW-1:0];
          default: ;
        endcase
      end
      if (fire) begin
        tcnt <= '0;
        if ({1'b0, nxt} < NST_V) state <= nxt;
      end else if (tick && tcnt != '1) begin
        tcnt <= tcnt + 1'b1;
      end
      if (ev_irq) irq <= 1'b1;
      else if (irq_clr) irq <= 1'b0;
    end
  end

  a_r1_reset_idle: assert property (@(posedge clk)
    !rst_n |=> (state == '0 && !irq && enables == '0));
  a_r3_hold_without_tick: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(state));
  a_r9_state_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    {1'b0, state} < NST_V);
  a_r7_irq_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !irq_clr) |=> irq);
  a_r7_irq_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_clr && !tick) |=> !irq);
  a_r5_fault_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && flt_hit && ({1'b0, t_ft[state]} < NST_V)) |=> (state == $past(t_ft[state]) && irq));
endmodule

// File: tb/test_seq_engine.sv
module test_seq_engine;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [7:0] flags = '0;
  logic sw_ctl = 1'b0, tick = 1'b0, cfg_we = 1'b0, irq_clr = 1'b0;
  logic [5:0] cfg_addr = '0;
  logic [3:0] cfg_field = '0;
  logic [15:0] cfg_wdata = '0;
  logic [7:0] enables;
  logic irq;
  logic [5:0] state;

  int checks = 0, fails = 0;
  bit done = 0;

  seq_engine i_seq_engine (
    .clk(clk), .rst_n(rst_n), .flags(flags), .sw_ctl(sw_ctl), .tick(tick),
    .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_field(cfg_field),
    .cfg_wdata(cfg_wdata), .irq_clr(irq_clr), .enables(enables), .irq(irq),
    .state(state));

  always #5 clk = ~clk;

  int m_tab [63][9];
  int m_state, m_tcnt;
  bit m_irq;

  function automatic bit hit(int mask, int match, int c);
    return (mask != 0) && (((c ^ match) & mask) == 0);
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_state <= 0; m_tcnt <= 0; m_irq <= 0;
      for (int i = 0; i < 63; i++)
        for (int f = 0; f < 9; f++) m_tab[i][f] <= 0;
    end else begin
      int c, tgt, lim;
      bit a, fl, t;
      if (cfg_we && cfg_addr < 63 && cfg_field < 9) begin
        lim = (cfg_field == 0) ? 'hff : (cfg_field == 7) ? 'hffff :
              (cfg_field inside {3, 6, 8}) ? 'h3f : 'h1ff;
        m_tab[cfg_addr][cfg_field] <= int'(cfg_wdata) & lim;
      end
      c  = {23'd0, sw_ctl, flags};
      a  = hit(m_tab[m_state][1], m_tab[m_state][2], c);
      fl = hit(m_tab[m_state][4], m_tab[m_state][5], c);
      t  = m_tab[m_state][7] != 0 && (m_tcnt + 1) >= m_tab[m_state][7];
      tgt = fl ? m_tab[m_state][6] : a ? m_tab[m_state][3] : m_tab[m_state][8];
      if (tick && (a || fl || t)) begin
        m_tcnt <= 0;
        if (tgt < 63) m_state <= tgt;
      end else if (tick && m_tcnt != 'hffff) m_tcnt <= m_tcnt + 1;
      if (tick && (fl || (t && !a))) m_irq <= 1;
      else if (irq_clr) m_irq <= 0;
    end
  end

  task automatic chk(string req, int act, int exp, string what);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic cmp_model(string req);
    chk(req, int'(state), m_state, "state");
    chk(req, int'(enables), m_tab[m_state][0], "enables");
    chk(req, int'(irq), int'(m_irq), "irq");
  endtask

  task automatic step(string req);
    @(posedge clk); #1;
    cmp_model(req);
  endtask

  task automatic wr(int a, int f, int d);
    cfg_we = 1; cfg_addr = 6'(a); cfg_field = 4'(f); cfg_wdata = 16'(d);
    step("R8");
    cfg_we = 0;
  endtask

  task automatic pulse(string req);
    tick = 1; step(req); tick = 0; step(req);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL R3 watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    @(posedge clk); #1; @(posedge clk); #1;
    chk("R1", int'(state), 0, "state"); chk("R1", int'(enables), 0, "enables");
    chk("R1", int'(irq), 0, "irq");
    rst_n = 1;
    step("R1");

    wr(0, 0, 'h01); wr(0, 1, 'h001); wr(0, 2, 'h001); wr(0, 3, 1);
    chk("R2", int'(enables), 'h01, "enables");
    wr(1, 0, 'h03); wr(1, 7, 3); wr(1, 8, 2);
    wr(1, 4, 'h080); wr(1, 5, 'h080); wr(1, 6, 5);
    wr(63, 0, 'hff);
    chk("R8", int'(enables), 'h01, "enables after dropped write");

    flags = 8'h01;
    repeat (3) step("R3");
    chk("R3", int'(state), 0, "state without tick");
    pulse("R4");
    chk("R4", int'(state), 1, "state"); chk("R2", int'(enables), 'h03, "enables");
    flags = 0;
    pulse("R6"); pulse("R6");
    chk("R6", int'(state), 1, "state before timeout");
    pulse("R6");
    chk("R6", int'(state), 2, "state after timeout");
    chk("R7", int'(irq), 1, "irq on timeout");
    repeat (2) step("R7");
    irq_clr = 1; step("R7"); irq_clr = 0;
    chk("R7", int'(irq), 0, "irq cleared");

    wr(2, 0, 'h07); wr(2, 1, 'h002); wr(2, 2, 'h002); wr(2, 3, 3);
    wr(2, 4, 'h002); wr(2, 5, 'h002); wr(2, 6, 4); wr(2, 7, 1); wr(2, 8, 6);
    flags = 8'h02;
    pulse("R5");
    chk("R5", int'(state), 4, "fault over advance");
    chk("R7", int'(irq), 1, "irq on fault");
    irq_clr = 1; step("R7"); irq_clr = 0;
    wr(4, 1, 'h004); wr(4, 2, 'h004); wr(4, 3, 3); wr(4, 7, 1); wr(4, 8, 6);
    flags = 8'h04;
    pulse("R5");
    chk("R5", int'(state), 3, "advance over timeout");
    chk("R5", int'(irq), 0, "no irq on advance");

    wr(3, 1, 'h100); wr(3, 2, 'h100); wr(3, 3, 10);
    flags = 8'hff; sw_ctl = 0;
    pulse("R4");
    chk("R4", int'(state), 3, "sw_ctl low");
    sw_ctl = 1;
    pulse("R4");
    chk("R4", int'(state), 10, "sw_ctl high");
    wr(10, 1, 'h100); wr(10, 2, 'h000); wr(10, 3, 63);
    sw_ctl = 0;
    pulse("R9");
    chk("R9", int'(state), 10, "invalid target held");
    chk("R2", int'(enables), 0, "enables of state 10");

    for (int s = 0; s < 8; s++) begin
      wr(s, 0, $urandom & 'hff);
      wr(s, 1, $urandom & $urandom & 'h1ff); wr(s, 2, $urandom & 'h1ff);
      wr(s, 3, ($urandom % 10 == 0) ? 63 : $urandom % 8);
      wr(s, 4, $urandom & $urandom & $urandom & 'h1ff); wr(s, 5, $urandom & 'h1ff);
      wr(s, 6, $urandom % 8);
      wr(s, 7, $urandom % 5); wr(s, 8, $urandom % 8);
    end
    wr(10, 1, 'h100); wr(10, 2, 'h100); wr(10, 3, 0);
    sw_ctl = 1; pulse("R4");
    for (int n = 0; n < 4000; n++) begin
      flags = 8'($urandom); sw_ctl = 1'($urandom);
      tick = ($urandom % 3 == 0); irq_clr = ($urandom % 8 == 0);
      step("R4");
    end
    tick = 0; irq_clr = 0;
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule